// File: doc/BRIEF.md
# PLL Operating Mode Controller

This block supervises a digitally controlled jitter-attenuating PLL. It decides which of four operating modes the loop is in: free-run, lock acquisition, locked or holdover. It moves between them based on whether the selected reference is present, whether phase lock has been reported and whether software is forcing a hold. The loop filter, the frequency averaging path and the oscillator are outside the block. They see only the mode code and a loop-bandwidth selection that this block drives.

The choice between holdover and free-run on reference loss depends on a history qualification timer. The timer counts enable ticks, one per 268 ns unit, while the reference is present. It stops counting while the reference is absent and continues from where it stopped when the reference returns. Its target is the sum of a power-of-two window and a power-of-two delay, each given by a 5-bit code.

The bandwidth selector does two jobs. It applies the fastlock set while loss-of-lock is raised. When ramped exit is bypassed, it uses an encoded select to pick the bandwidth for acquisition after holdover. A hold status bit feeds a sticky flag and a maskable interrupt.

States and transitions:
- FREE (free-run): goes to ACQ when the input is valid.
- ACQ (lock acquisition): goes to LOCK on phase lock. On input loss it goes to HOLD if history is valid, and to FREE otherwise.
- LOCK (locked): on input loss it goes to HOLD or FREE, chosen the same way.
- HOLD (holdover): returns to ACQ when the input is valid again.
- Force hold, from any state: goes to HOLD if history is valid, and to FREE otherwise.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While reset is low, mode is 00 (free-run), bw_sel is 00 (normal), hist_valid is 0 and hold_flag is 0.
- R2: Mode codes are 00 free-run, 01 acquisition, 10 locked and 11 holdover. From free-run, a valid input moves the mode to acquisition on the next edge. From acquisition, phase_locked moves it to locked on the next edge.
- R3: Input loss in acquisition or locked moves the mode to holdover when hist_valid is 1, and to free-run when it is 0. From holdover, a valid input moves the mode to acquisition.
- R4: hist_valid becomes 1 after exactly (2^L − 1) + 2^D edges on which both tick and in_valid were high, where L is hist_len_code and D is hist_dly_code.
- R5: Edges with in_valid low, or with tick low, do not advance the history count. Counting resumes from the held count when the input returns.
- R6: bw_sel encodes 00 normal, 01 fastlock and 10 holdover-exit. Outside a holdover exit, bw_sel is 01 while fastlock_en and lol are both high, and 00 otherwise.
- R7: With ramp_bypass high, the transition from holdover to acquisition sets bw_sel from exit_bw_sel: 00 gives 01, 01 gives 10, and 10 or 11 give 00. That value holds until the next state change. With ramp_bypass low, no exit bandwidth is applied.
- R8: While force_hold is high, the mode goes to holdover if hist_valid is 1, and to free-run otherwise, whatever the state of in_valid.
- R9: hold_stat is 1 in free-run and holdover. hold_flag is set on any edge where hold_stat is 1. A flag_clr strobe clears it only on an edge where hold_stat is 0.
- R10: irq follows hold_flag when irq_mask is 0, and is 0 when irq_mask is 1.
- R11: bw_sel changes only on an edge where the mode changes or where lol differs from its value on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One 268 ns time unit enable |
| in_valid | input | 1 | Selected input clock is qualified |
| phase_locked | input | 1 | Phase lock achieved on the selected input |
| lol | input | 1 | Live loss-of-lock |
| force_hold | input | 1 | Force holdover or free-run |
| fastlock_en | input | 1 | Enable fastlock bandwidth during loss-of-lock |
| ramp_bypass | input | 1 | Bypass ramped holdover exit |
| exit_bw_sel | input | 2 | Exit bandwidth select |
| hist_len_code | input | 5 | History window code L |
| hist_dly_code | input | 5 | History delay code D |
| flag_clr | input | 1 | Write-zero strobe to the sticky hold flag |
| irq_mask | input | 1 | 1 suppresses the interrupt |
| mode | output | 2 | Current operating mode |
| bw_sel | output | 2 | Selected loop bandwidth set |
| hold_stat | output | 1 | Live holdover/free-run status |
| hist_valid | output | 1 | History qualified |
| hold_flag | output | 1 | Sticky hold flag |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach from the ports is the holdover-exit bandwidth. It needs a qualified history, an input loss that lands in holdover, and then a return of the input with the bypass set. The bench uses the smallest codes, so history qualifies after one counted tick. It then walks lock, loss and return for each of the four select values, and raises lol during the exit to show the choice is held. The boundary of the history timer is swept over a 4×4 grid of codes, with the count checked one edge before and on the exact edge. A separate run takes the input away partway through to show the count pausing.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_ACQ  = 2'b01,
        MODE_LOCK = 2'b10,
        MODE_HOLD = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        BW_NORMAL = 2'b00,
        BW_FAST   = 2'b01,
        BW_EXIT   = 2'b10
    } bw_e;

    function automatic bw_e exit_decode(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return BW_FAST;
            2'b01:   return BW_EXIT;
            default: return BW_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/pll_hist_timer.sv
module pll_hist_timer #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] len_code,
    input  logic [CODE_W-1:0] dly_code,
    output logic              hist_valid
);
    localparam int CNT_W = (1 << CODE_W) + 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] target;

    // window (2^L - 1) plus delay 2^D, in tick units
    assign target     = ((ONE << len_code) - ONE) + (ONE << dly_code);
    assign hist_valid = (cnt_q >= target);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick && in_valid && !hist_valid) begin
            cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/pll_bw_pick.sv
module pll_bw_pick
    import pll_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mode_e      state_q,
    input  mode_e      state_d,
    input  logic       lol,
    input  logic       fastlock_en,
    input  logic       ramp_bypass,
    input  logic [1:0] exit_bw_sel,
    output logic [1:0] bw_sel
);
    bw_e  bw_q;
    logic exit_q;
    logic lol_q;
    logic moved;
    logic exit_entry;
    bw_e  live_bw;

    assign moved      = (state_q != state_d);
    assign exit_entry = (state_q == MODE_HOLD) && (state_d == MODE_ACQ) && ramp_bypass;
    assign live_bw    = (fastlock_en && lol) ? BW_FAST : BW_NORMAL;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bw_q   <= BW_NORMAL;
            exit_q <= 1'b0;
            lol_q  <= 1'b0;
        end else begin
            lol_q <= lol;
            if (moved) begin
                exit_q <= exit_entry;
                bw_q   <= exit_entry ? exit_decode(exit_bw_sel) : live_bw;
            end else if ((lol != lol_q) && !exit_q) begin
                bw_q <= live_bw;
            end
        end
    end

    assign bw_sel = bw_q;
endmodule

// File: rtl/pll_hold_flag.sv
module pll_hold_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_stat,
    input  logic flag_clr,
    input  logic irq_mask,
    output logic hold_flag,
    output logic irq
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hold_stat) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign hold_flag = flag_q;
    assign irq       = flag_q && !irq_mask;
endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
    import pll_mode_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              in_valid,
    input  logic              phase_locked,
    input  logic              lol,
    input  logic              force_hold,
    input  logic              fastlock_en,
    input  logic              ramp_bypass,
    input  logic [1:0]        exit_bw_sel,
    input  logic [CODE_W-1:0] hist_len_code,
    input  logic [CODE_W-1:0] hist_dly_code,
    input  logic              flag_clr,
    input  logic              irq_mask,
    output logic [1:0]        mode,
    output logic [1:0]        bw_sel,
    output logic              hold_stat,
    output logic              hist_valid,
    output logic              hold_flag,
    output logic              irq
);
    mode_e state_q;
    mode_e state_d;
    mode_e loss_target;

    pll_hist_timer #(.CODE_W(CODE_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .in_valid  (in_valid),
        .len_code  (hist_len_code),
        .dly_code  (hist_dly_code),
        .hist_valid(hist_valid)
    );

    assign loss_target = hist_valid ? MODE_HOLD : MODE_FREE;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_FREE;
        else        state_q <= state_d;
    end

    // next-state
    always_comb begin
        state_d = state_q;
        if (force_hold) begin
            state_d = loss_target;
        end else begin
            unique case (state_q)
                MODE_FREE: if (in_valid) state_d = MODE_ACQ;
                MODE_ACQ: begin
                    if (!in_valid)        state_d = loss_target;
                    else if (phase_locked) state_d = MODE_LOCK;
                end
                MODE_LOCK: if (!in_valid) state_d = loss_target;
                MODE_HOLD: if (in_valid)  state_d = MODE_ACQ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mode      = state_q;
        hold_stat = (state_q == MODE_FREE) || (state_q == MODE_HOLD);
    end

    pll_bw_pick u_bw (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .state_d    (state_d),
        .lol        (lol),
        .fastlock_en(fastlock_en),
        .ramp_bypass(ramp_bypass),
        .exit_bw_sel(exit_bw_sel),
        .bw_sel     (bw_sel)
    );

    pll_hold_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_stat(hold_stat),
        .flag_clr (flag_clr),
        .irq_mask (irq_mask),
        .hold_flag(hold_flag),
        .irq      (irq)
    );
endmodule

// File: rtl/pll_mode_ctrl_chk.sv
module pll_mode_ctrl_chk
    import pll_mode_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              lol,
    input logic              force_hold,
    input logic              flag_clr,
    input logic [CODE_W-1:0] hist_len_code,
    input logic [CODE_W-1:0] hist_dly_code,
    input logic [1:0]        mode,
    input logic [1:0]        bw_sel,
    input logic              hold_stat,
    input logic              hist_valid,
    input logic              hold_flag
);
    // R2: locked is entered only from acquisition
    a_r2_lock_from_acq: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOCK) |-> ($past(mode) == MODE_ACQ || $past(mode) == MODE_LOCK));

    // R3: input loss while locked picks holdover or free-run by history
    a_r3_loss_target: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOCK && !in_valid && !force_hold)
        |=> (mode == ($past(hist_valid) ? MODE_HOLD : MODE_FREE)));

    // R5: qualified history stays qualified while codes are unchanged
    a_r5_hist_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        hist_valid |=> (hist_valid || $past(hist_len_code) != hist_len_code
                                  || $past(hist_dly_code) != hist_dly_code));

    // R8: force hold ends in a hold-status state
    a_r8_force_hold: assert property (@(posedge clk) disable iff (!rst_n)
        force_hold |=> hold_stat);

    // R9: sticky flag set by status, kept without a clear strobe
    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        hold_stat |=> hold_flag);

    a_r9_flag_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_flag && !flag_clr) |=> hold_flag);

    // R11: bandwidth moves only with a mode change or a lol edge
    a_r11_bw_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && bw_sel != $past(bw_sel))
        |-> (mode != $past(mode) || $past(lol) != $past(lol, 2)));
endmodule

bind pll_mode_ctrl pll_mode_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .lol          (lol),
    .force_hold   (force_hold),
    .flag_clr     (flag_clr),
    .hist_len_code(hist_len_code),
    .hist_dly_code(hist_dly_code),
    .mode         (mode),
    .bw_sel       (bw_sel),
    .hold_stat    (hold_stat),
    .hist_valid   (hist_valid),
    .hold_flag    (hold_flag)
);

// File: tb/pll_mode_ctrl_test.sv
module pll_mode_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n, tick, in_valid, phase_locked, lol, force_hold;
    logic       fastlock_en, ramp_bypass, flag_clr, irq_mask;
    logic [1:0] exit_bw_sel;
    logic [4:0] hist_len_code, hist_dly_code;
    logic [1:0] mode, bw_sel;
    logic       hold_stat, hist_valid, hold_flag, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    pll_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
        .phase_locked(phase_locked), .lol(lol), .force_hold(force_hold),
        .fastlock_en(fastlock_en), .ramp_bypass(ramp_bypass),
        .exit_bw_sel(exit_bw_sel), .hist_len_code(hist_len_code),
        .hist_dly_code(hist_dly_code), .flag_clr(flag_clr), .irq_mask(irq_mask),
        .mode(mode), .bw_sel(bw_sel), .hold_stat(hold_stat),
        .hist_valid(hist_valid), .hold_flag(hold_flag), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input int l, input int d);
        rst_n = 0; tick = 1; in_valid = 0; phase_locked = 0; lol = 0;
        force_hold = 0; fastlock_en = 0; ramp_bypass = 0; exit_bw_sel = 2'b00;
        flag_clr = 0; irq_mask = 0;
        hist_len_code = 5'(l); hist_dly_code = 5'(d);
        repeat (3) step();
        rst_n = 1;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset(3, 3);
        rst_n = 0; in_valid = 1;
        step();
        check("R1 mode", mode, 0);
        check("R1 bw", bw_sel, 0);
        check("R1 hist", hist_valid, 0);
        check("R1 flag", hold_flag, 0);

        // R4 timer boundary sweep, R2 free-run to acquisition
        for (int l = 0; l < 4; l++) begin
            for (int d = 0; d < 4; d++) begin
                int tgt;
                tgt = ((1 << l) - 1) + (1 << d);
                do_reset(l, d);
                in_valid = 1;
                repeat (tgt - 1) step();
                check("R4 before", hist_valid, 0);
                step();
                check("R4 at", hist_valid, 1);
                check("R2 acq", mode, 1);
            end
        end

        // R5 pause while input absent and while tick low
        do_reset(2, 1);                       // target 5
        in_valid = 1;
        repeat (2) step();
        in_valid = 0;
        repeat (10) step();
        check("R5 paused", hist_valid, 0);
        in_valid = 1; tick = 0;
        repeat (6) step();
        check("R5 no tick", hist_valid, 0);
        tick = 1;
        repeat (2) step();
        check("R5 resumed", hist_valid, 0);
        step();
        check("R5 resumed done", hist_valid, 1);

        // R2, R3 lock and loss with history valid
        do_reset(0, 0);
        in_valid = 1;
        step();
        check("R2 acq", mode, 1);
        phase_locked = 1;
        step();
        check("R2 lock", mode, 2);
        check("R9 stat lock", hold_stat, 0);
        in_valid = 0; phase_locked = 0;
        step();
        check("R3 hold", mode, 3);
        check("R9 stat hold", hold_stat, 1);
        in_valid = 1;
        step();
        check("R3 exit", mode, 1);

        // R3 loss without history
        do_reset(3, 3);
        in_valid = 1;
        step();
        phase_locked = 1;
        step();
        in_valid = 0; phase_locked = 0;
        step();
        check("R3 free", mode, 0);

        // R8 force hold
        do_reset(3, 3);                       // target 15
        in_valid = 1;
        step();
        force_hold = 1;
        step();
        check("R8 force free", mode, 0);
        repeat (14) step();
        check("R8 force hold", mode, 3);
        force_hold = 0;
        step();
        check("R8 release", mode, 1);

        // R6 fastlock, R11 no change without cause
        do_reset(3, 3);
        fastlock_en = 1; in_valid = 1;
        step();
        lol = 1;
        step();
        check("R6 fast", bw_sel, 1);
        lol = 0;
        step();
        check("R6 normal", bw_sel, 0);
        fastlock_en = 0; lol = 1;
        step();
        check("R6 disabled", bw_sel, 0);
        fastlock_en = 1;
        step();
        check("R11 no edge", bw_sel, 0);

        // R7 exit bandwidth select sweep
        for (int s = 0; s < 4; s++) begin
            int e;
            e = (s == 0) ? 1 : (s == 1) ? 2 : 0;
            do_reset(0, 0);
            ramp_bypass = 1; exit_bw_sel = 2'(s);
            in_valid = 1;
            step();
            in_valid = 0;
            step();
            check("R7 in hold", mode, 3);
            in_valid = 1;
            step();
            check("R7 exit bw", bw_sel, 32'(e));
            fastlock_en = 1; lol = 1;
            step();
            check("R7 held", bw_sel, 32'(e));
            lol = 0; phase_locked = 1;
            step();
            check("R7 locked bw", bw_sel, 0);
        end
        do_reset(0, 0);
        ramp_bypass = 0; exit_bw_sel = 2'b01;
        in_valid = 1;
        step();
        in_valid = 0;
        step();
        in_valid = 1;
        step();
        check("R7 ramp", bw_sel, 0);

        // R9 sticky flag, R10 mask
        do_reset(3, 3);
        flag_clr = 1;
        step();
        check("R9 set", hold_flag, 1);
        check("R10 irq", irq, 1);
        irq_mask = 1;
        #1;
        check("R10 masked", irq, 0);
        in_valid = 1;
        step();
        check("R9 clr blocked", hold_flag, 1);
        step();
        check("R9 cleared", hold_flag, 0);
        irq_mask = 0;
        #1;
        check("R10 idle", irq, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule